// File: doc/BRIEF.md
# Acquisition Trigger and Autoscan Sequencer

This block sits in front of an analog-to-digital converter. It decides the cycle in which each conversion begins and which input channel the conversion samples. A byte-wide register port holds a trigger control byte, a channel value and a 3-bit gain code. The block drives a one-cycle convert-start pulse, the channel number for that conversion and the gain code, and it reports a busy flag while a conversion is in progress.

Three sources can start a conversion: a write to the software trigger address, a pacer tick input, or a rising edge on an asynchronous external trigger pin. Two control bits choose the source, and software is the default. With autoscan on, each conversion samples the next channel in the range from 0 up to a programmed last channel, then wraps back to 0. With autoscan off, the channel value picks one fixed channel.

Top module: `acq_trig_seq`

## Requirements
- R1: After reset, conv_start and busy are 0, conv_chan and conv_gain are 0, and the control, channel and gain registers read back as 0.
- R2: Address 0 is the control register. Bits 5:0 are stored and read back unchanged, and bits 7:6 read as 0. Bit 0 enables autoscan, bit 1 selects the pacer source, and bit 2 selects the external source. Bits 3, 4 and 5 are flags that are stored only.
- R3: When control bits 2 and 1 are both 0, a write of any value to address 3 while busy is low raises conv_start for one cycle, in the cycle after the write edge. When either bit is 1, writes to address 3 start nothing.
- R4: When control bit 1 is 1 and bit 2 is 0, pacer_tick high at a clock edge while busy is low raises conv_start in the following cycle. In any other mode, pacer_tick starts nothing.
- R5: When control bit 2 is 1 (this takes priority over bit 1), a rising edge of ext_trig passes through a two-flop synchronizer and raises conv_start in the third cycle after the first edge that samples ext_trig high. If ext_trig is then held high, no further conversion starts. When bit 2 is 0, ext_trig starts nothing.
- R6: busy rises together with conv_start and stays high for exactly BUSY_CYC cycles. A trigger that arrives while busy is high is dropped and does not advance the scan.
- R7: With autoscan off, conv_chan equals the channel register (address 1, bits 3:0) at each conversion.
- R8: With autoscan on and channel register value N, successive conversions sample channels 0, 1, ... N, then 0 again.
- R9: A write to the channel register returns the autoscan position to channel 0.
- R10: A write to address 2 stores bits 2:0 as the gain code. That code drives conv_gain and reads back in bits 2:0 of address 2. Bit 7 of address 2 reads the busy flag, and bits 6:3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| pacer_tick | input | 1 | Pacer timer tick |
| ext_trig | input | 1 | Asynchronous external trigger |
| conv_start | output | 1 | One-cycle convert-start pulse |
| conv_chan | output | 4 | Channel of the current conversion |
| conv_gain | output | 3 | Gain code applied to the converter |
| busy | output | 1 | Converter busy |

## Verification
The hardest case to reach is a trigger landing in the last busy cycle, just before busy falls, combined with the scan wrapping at N. That dropped trigger must neither start a conversion nor advance the channel. The stimulus issues back-to-back software writes in autoscan mode right after a start. It then runs random scan lengths with the expected position tracked in the bench, so a skipped or repeated channel shows up at the next accepted conversion. The external path is driven with a held-high level to show that only one conversion follows the edge.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

    localparam int GAIN_W = 3;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       evt_flag;
        logic       post_flag;
        logic       pre_en;
        logic       ext_sel;
        logic       pacer_sel;
        logic       scan_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_CHAN   = 2'd1,
        REG_GAIN   = 2'd2,
        REG_SWTRIG = 2'd3
    } reg_addr_t;

    typedef enum logic [1:0] {
        SRC_SW    = 2'd0,
        SRC_PACER = 2'd1,
        SRC_EXT   = 2'd2
    } src_t;

    function automatic src_t pick_src(input ctrl_t c);
        if (c.ext_sel)        return SRC_EXT;
        else if (c.pacer_sel) return SRC_PACER;
        else                  return SRC_SW;
    endfunction

endpackage

// File: rtl/acq_regs.sv
module acq_regs
    import acq_trig_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 busy,
    output logic [DATA_W-1:0]    rdata,
    output ctrl_t                ctrl,
    output logic [CH_W-1:0]      chan,
    output logic [GAIN_W-1:0]    gain,
    output logic                 sw_stb,
    output logic                 chan_wr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            chan <= '0;
            gain <= '0;
        end else if (wr_en) begin
            case (reg_addr_t'(addr))
                REG_CTRL: ctrl <= ctrl_t'({2'b00, wdata[5:0]});
                REG_CHAN: chan <= wdata[CH_W-1:0];
                REG_GAIN: gain <= wdata[GAIN_W-1:0];
                default:  ;
            endcase
        end
    end

    assign sw_stb  = wr_en && (reg_addr_t'(addr) == REG_SWTRIG);
    assign chan_wr = wr_en && (reg_addr_t'(addr) == REG_CHAN);

    always_comb begin
        rdata = '0;
        case (reg_addr_t'(addr))
            REG_CTRL: rdata = ctrl;
            REG_CHAN: rdata[CH_W-1:0] = chan;
            REG_GAIN: begin
                rdata[GAIN_W-1:0] = gain;
                rdata[DATA_W-1]   = busy;
            end
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/acq_trig_sel.sv
module acq_trig_sel
    import acq_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  sw_stb,
    input  logic  pacer_tick,
    input  logic  ext_trig,
    output logic  trig_req
);
    logic [SYNC_STAGES:0] sync_q;

    generate
        for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)         sync_q[i] <= 1'b0;
                else if (i == 0) sync_q[i] <= ext_trig;
                else             sync_q[i] <= sync_q[i-1];
            end
        end
    endgenerate

    logic ext_rise;
    assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    always_comb begin
        case (pick_src(ctrl))
            SRC_PACER: trig_req = pacer_tick;
            SRC_EXT:   trig_req = ext_rise;
            default:   trig_req = sw_stb;
        endcase
    end
endmodule

// File: rtl/acq_scan.sv
module acq_scan #(
    parameter int CH_W     = 4,
    parameter int BUSY_CYC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trig_req,
    input  logic            scan_en,
    input  logic [CH_W-1:0] chan,
    input  logic            chan_wr,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_chan,
    output logic            busy
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CH_W-1:0]  pos_q;
    logic             fire;

    assign busy = (cnt_q != '0);
    assign fire = trig_req && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            conv_start <= 1'b0;
            conv_chan  <= '0;
        end else begin
            conv_start <= fire;
            if (fire) begin
                cnt_q     <= CNT_W'(BUSY_CYC);
                conv_chan <= scan_en ? pos_q : chan;
            end else if (busy) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || chan_wr)
            pos_q <= '0;
        else if (fire && scan_en)
            pos_q <= (pos_q >= chan) ? '0 : pos_q + 1'b1;
    end
endmodule

// File: rtl/acq_trig_seq.sv
module acq_trig_seq
    import acq_trig_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int BUSY_CYC = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic        pacer_tick,
    input  logic        ext_trig,
    output logic        conv_start,
    output logic [3:0]  conv_chan,
    output logic [2:0]  conv_gain,
    output logic        busy
);
    localparam int CH_W = $clog2(NUM_CH);

    ctrl_t            ctrl_w;
    logic [CH_W-1:0]  chan_w;
    logic             sw_stb;
    logic             chan_wr;
    logic             trig_req;

    acq_regs #(.CH_W(CH_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .rdata(rdata), .ctrl(ctrl_w), .chan(chan_w),
        .gain(conv_gain), .sw_stb(sw_stb), .chan_wr(chan_wr)
    );

    acq_trig_sel #(.SYNC_STAGES(2)) u_sel (
        .clk(clk), .rst(rst), .ctrl(ctrl_w), .sw_stb(sw_stb),
        .pacer_tick(pacer_tick), .ext_trig(ext_trig), .trig_req(trig_req)
    );

    acq_scan #(.CH_W(CH_W), .BUSY_CYC(BUSY_CYC)) u_scan (
        .clk(clk), .rst(rst), .trig_req(trig_req), .scan_en(ctrl_w.scan_en),
        .chan(chan_w), .chan_wr(chan_wr), .conv_start(conv_start),
        .conv_chan(conv_chan), .busy(busy)
    );
endmodule

// File: rtl/acq_trig_chk.sv
module acq_trig_chk #(
    parameter int CH_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [1:0]      addr,
    input logic            pacer_tick,
    input logic            conv_start,
    input logic [3:0]      conv_chan,
    input logic            busy,
    input logic [7:0]      ctrl,
    input logic [CH_W-1:0] chan
);
    a_r6_busy_with_start: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> busy);

    a_r6_no_start_while_busy: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !$past(busy));

    a_r3_sw_start: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd3 && ctrl[2:1] == 2'b00 && !busy) |=> conv_start);

    a_r4_pacer_start: assert property (@(posedge clk) disable iff (rst)
        (pacer_tick && ctrl[2:1] == 2'b01 && !busy) |=> conv_start);

    a_r7_single_chan: assert property (@(posedge clk) disable iff (rst)
        (conv_start && !ctrl[0] && $stable(chan) && $stable(ctrl)) |-> (conv_chan == 4'(chan)));
endmodule

bind acq_trig_seq acq_trig_chk #(.CH_W(CH_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .pacer_tick(pacer_tick),
    .conv_start(conv_start), .conv_chan(conv_chan), .busy(busy),
    .ctrl(ctrl_w), .chan(chan_w)
);

// File: tb/sim_acq_trig_seq.sv
`timescale 1ns/1ps
module sim_acq_trig_seq;
    localparam int BC = 5;

    logic clk = 0, rst = 1, wr_en = 0, pacer_tick = 0, ext_trig = 0;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic conv_start, busy;
    logic [3:0] conv_chan;
    logic [2:0] conv_gain;

    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    acq_trig_seq #(.NUM_CH(16), .BUSY_CYC(BC)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pacer_tick(pacer_tick), .ext_trig(ext_trig),
        .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_gain(conv_gain), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int next_pos(input int p, input int n);
        return (p >= n) ? 0 : p + 1;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int pos, n, cnt;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 conv_start", conv_start, 0);
        chk("R1 busy", busy, 0);
        chk("R1 conv_chan", conv_chan, 0);
        chk("R1 conv_gain", conv_gain, 0);
        rd(2'd0, d); chk("R1 ctrl", d, 0);
        rd(2'd2, d); chk("R1 status", d, 0);

        // R2 readback
        wr(2'd0, 8'hF8); rd(2'd0, d); chk("R2 ctrl readback", d, 8'h38);
        wr(2'd0, 8'h00);

        // R10 gain
        wr(2'd2, 8'hFC); chk("R10 conv_gain", conv_gain, 4);
        rd(2'd2, d); chk("R10 status gain", d, 4);

        // R3 software start, R6 busy length, R7 single channel
        wr(2'd1, 8'h09);
        wr(2'd3, 8'h00);
        chk("R3 sw start", conv_start, 1);
        chk("R7 chan", conv_chan, 9);
        chk("R6 busy at start", busy, 1);
        rd(2'd2, d); chk("R10 status busy", d[7], 1);
        chk("R3 one cycle", conv_start, 0);
        idle(BC - 2); chk("R6 busy last", busy, 1);
        idle(1); chk("R6 busy low", busy, 0);

        // R4 pacer mode, sw ignored
        wr(2'd0, 8'h02);
        wr(2'd3, 8'h00); chk("R3 sw ignored in pacer", conv_start, 0);
        @(negedge clk); pacer_tick = 1;
        @(negedge clk); pacer_tick = 0;
        chk("R4 pacer start", conv_start, 1);
        idle(BC + 1);
        // pacer ignored in sw mode
        wr(2'd0, 8'h00);
        @(negedge clk); pacer_tick = 1;
        @(negedge clk); pacer_tick = 0;
        chk("R4 pacer ignored in sw", conv_start, 0);

        // R5 external, priority over pacer, held high yields one start
        wr(2'd0, 8'h06);
        @(negedge clk); pacer_tick = 1;
        @(negedge clk); pacer_tick = 0;
        chk("R5 pacer ignored when ext", conv_start, 0);
        @(negedge clk); ext_trig = 1;
        @(negedge clk); chk("R5 early1", conv_start, 0);
        @(negedge clk); chk("R5 early2", conv_start, 0);
        @(negedge clk); chk("R5 ext start", conv_start, 1);
        cnt = 0;
        for (int i = 0; i < BC + 6; i++) begin @(negedge clk); cnt += conv_start; end
        chk("R5 held high single", cnt, 0);
        ext_trig = 0;
        wr(2'd0, 8'h00);
        @(negedge clk); ext_trig = 1;
        cnt = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); cnt += conv_start; end
        chk("R5 ext ignored in sw", cnt, 0);
        ext_trig = 0;

        // R8/R6 autoscan, dropped trigger while busy
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h02);
        wr(2'd3, 8'h00); chk("R8 ch0", conv_chan, 0);
        wr(2'd3, 8'h00); chk("R6 dropped", conv_start, 0);
        idle(BC);
        wr(2'd3, 8'h00); chk("R8 ch1", conv_chan, 1);
        idle(BC);
        wr(2'd3, 8'h00); chk("R8 ch2", conv_chan, 2);
        idle(BC);
        wr(2'd3, 8'h00); chk("R8 wrap", conv_chan, 0);
        idle(BC);
        // R9 channel write resets position
        wr(2'd1, 8'h02);
        wr(2'd3, 8'h00); chk("R9 reset pos", conv_chan, 0);
        idle(BC);

        // random autoscan runs
        void'($urandom(32'd1234));
        for (int r = 0; r < 20; r++) begin
            n = $urandom_range(0, 15);
            wr(2'd1, 8'(n));
            pos = 0;
            for (int k = 0; k < 24; k++) begin
                wr(2'd3, 8'($urandom));
                chk("R8 random start", conv_start, 1);
                chk("R8 random chan", conv_chan, pos);
                pos = next_pos(pos, n);
                idle(BC - 1 + $urandom_range(0, 2));
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule